// File: doc/BRIEF.md
# Smart Card Character Receiver

This block receives asynchronous characters from a smart card over one shared, open-drain I/O line. Each character has a low start bit, eight data bits sent least significant bit first, and one even-parity bit. Bit timing comes from a programmable count of clock cycles per elementary time unit (ETU). A falling edge starts a frame only if the line is still low half an ETU later. Each later bit is sampled in the middle of its ETU.

When the parity is correct, the byte is placed in the data register and a ready flag is raised. The ready flag also serves as the transfer request to a DMA engine, and a DMA acknowledge clears it. When the parity is wrong, the byte is still stored, but a parity-error flag is raised instead of ready. The receiver then pulls the line low for one ETU so that the card sends the character again. If a character finishes while ready is still set, an overrun flag is raised and the unread byte is kept. A single enable gates both interrupt requests: one for a received character and one for errors. Software clears each flag with a write-one strobe.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, the following outputs are all low: `rdy_flag`, `perr_flag`, `ovr_flag`, `rxi_irq`, `eri_irq`, `dma_req` and `io_drive_low`. `rd_data` is zero.
- R2: The first data bit after the start bit is stored in bit 0 of `rd_data`. A character whose nine data-plus-parity bits contain an even number of ones loads `rd_data`, sets `rdy_flag` and leaves `perr_flag` clear.
- R3: A character with odd parity sets `perr_flag` and never sets `rdy_flag`. Its byte is still loaded into `rd_data`.
- R4: After an odd-parity character, `io_drive_low` is high for exactly `etu_div` cycles, starting one ETU after the parity mid-bit sample. After an even-parity character it stays low.
- R5: `rxi_irq` is high exactly when `rdy_flag` and `rx_irq_en` are both high. `eri_irq` is high exactly when `rx_irq_en` is high and `perr_flag` or `ovr_flag` is high.
- R6: `dma_req` is high while `rdy_flag` is high. A cycle with `dma_ack` high clears `rdy_flag`.
- R7: A character that completes while `rdy_flag` is high sets `ovr_flag` and leaves `rd_data` unchanged.
- R8: A high `clr_rdy`, `clr_perr` or `clr_ovr` clears its flag on the next edge. If the same edge would also set that flag, the set wins.
- R9: A low pulse on the line that is high again at the half-ETU check starts no frame. It changes no flag and causes no error drive.
- R10: While `rx_en` is low, characters on the line are ignored and `io_drive_low` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| rx_irq_en | input | 1 | Enable for both interrupt requests |
| etu_div | input | DIV_W | Clock cycles per ETU (at least 2) |
| io_in | input | 1 | Level of the shared I/O line |
| io_drive_low | output | 1 | Pull the I/O line low (error signal) |
| rd_data | output | DATA_W | Received byte |
| rdy_flag | output | 1 | Good character waiting to be read |
| perr_flag | output | 1 | Parity error seen |
| ovr_flag | output | 1 | Character completed while ready was set |
| clr_rdy | input | 1 | Write-one clear of the ready flag |
| clr_perr | input | 1 | Write-one clear of the parity-error flag |
| clr_ovr | input | 1 | Write-one clear of the overrun flag |
| dma_req | output | 1 | Transfer request for a good character |
| dma_ack | input | 1 | Transfer acknowledge; clears the ready flag |
| rxi_irq | output | 1 | Receive interrupt request |
| eri_irq | output | 1 | Error interrupt request |

## Verification
The line passes through a two-flop synchronizer, so every sample lands two cycles after the bench changes the line. The flags and `rd_data` change one cycle after the parity mid-bit sample. The error drive begins one ETU after that sample and lasts one ETU.

The bench therefore does not wait a fixed number of cycles for results. A monitor samples on falling clock edges and checks each character the moment `rdy_flag` or `perr_flag` rises. The driver counts the cycles of error drive over a three-ETU window after the parity bit. Steady-state checks such as overrun, clears, interrupts and the false-start case run only once the whole frame and its guard time have passed.

// File: rtl/sc_rx_pkg.sv
// Package: shared types for the smart card character receiver.
// Assumes one start bit, DATA_W data bits and one parity bit per frame.
package sc_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_START   = 3'd1,
        S_DATA    = 3'd2,
        S_PARITY  = 3'd3,
        S_ERRWAIT = 3'd4,
        S_ERRDRV  = 3'd5,
        S_GUARD   = 3'd6
    } rx_state_t;
endpackage

// File: rtl/sc_etu_timer.sv
// Module: down-counting interval timer.
// After a load with value N, `done` is high in the cycle before the N-th
// edge that follows the load, so the owner acts exactly N cycles after loading.
// Assumes N >= 1. A load issued in the same cycle as `done` restarts the count.
module sc_etu_timer #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    output logic             done
);
    logic [DIV_W-1:0] cnt;

    // Load the interval or count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // The interval ends when the count is about to reach zero.
    always_comb done = (cnt == DIV_W'(1));
endmodule

// File: rtl/sc_rx_seq.sv
// Module: frame sequencer. Handles start confirmation, mid-bit sampling,
// the parity check, the error-signal window and the guard time.
// Assumes `line_s` is already synchronized to clk.
// `fin` is a one-cycle pulse at the parity sample. `bad` and `byte_out` are
// valid during that pulse.
module sc_rx_seq
    import sc_rx_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              line_s,
    input  logic [DIV_W-1:0]  etu_div,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic [DIV_W-1:0]  tmr_val,
    output logic              fin,
    output logic              bad,
    output logic [DATA_W-1:0] byte_out,
    output logic              drive_low
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    rx_state_t         state, nxt;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] sh;
    logic [DIV_W-1:0]  half_etu;

    // Half an ETU, never shorter than one cycle.
    always_comb half_etu = ((etu_div >> 1) == '0) ? DIV_W'(1) : (etu_div >> 1);

    // Choose the next state and reload the timer on each transition.
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = etu_div;
        fin      = 1'b0;
        unique case (state)
            S_IDLE: if (!line_s) begin
                nxt = S_START; tmr_load = 1'b1; tmr_val = half_etu;
            end
            S_START: if (tmr_done) begin
                nxt      = line_s ? S_IDLE : S_DATA;
                tmr_load = !line_s;
            end
            S_DATA: if (tmr_done) begin
                tmr_load = 1'b1;
                if (bitcnt == CNT_W'(DATA_W - 1)) nxt = S_PARITY;
            end
            S_PARITY: if (tmr_done) begin
                fin      = 1'b1;
                tmr_load = 1'b1;
                nxt      = bad ? S_ERRWAIT : S_GUARD;
            end
            S_ERRWAIT: if (tmr_done) begin
                nxt = S_ERRDRV; tmr_load = 1'b1;
            end
            S_ERRDRV: if (tmr_done) begin
                nxt = S_GUARD; tmr_load = 1'b1;
            end
            S_GUARD: if (tmr_done) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
        if (!rx_en) begin
            nxt      = S_IDLE;
            tmr_load = 1'b0;
            fin      = 1'b0;
        end
    end

    // Advance the frame state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Shift data bits in LSB first and count them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            bitcnt <= '0;
        end else if (state == S_START) begin
            bitcnt <= '0;
        end else if (state == S_DATA && tmr_done) begin
            sh     <= {line_s, sh[DATA_W-1:1]};
            bitcnt <= bitcnt + 1'b1;
        end
    end

    // Even parity over the data and parity bits; `bad` is read only in S_PARITY.
    always_comb bad = (^sh) ^ line_s;
    always_comb byte_out = sh;

    // Pull the line low only inside the error-signal ETU.
    always_comb drive_low = (state == S_ERRDRV);
endmodule

// File: rtl/sc_rx_flags.sv
// Module: data register, status flags, DMA request and interrupt requests.
// Assumes `fin` is a single-cycle pulse. In every flag a set beats a clear.
module sc_rx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin,
    input  logic              bad,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              irq_en,
    input  logic              clr_rdy,
    input  logic              clr_perr,
    input  logic              clr_ovr,
    input  logic              dma_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy,
    output logic              perr,
    output logic              ovr,
    output logic              rxi,
    output logic              eri,
    output logic              dma_req
);
    logic set_rdy, set_perr, set_ovr, load_data;

    // Decode the completion event into the individual flag sets.
    always_comb begin
        load_data = fin && !rdy;
        set_rdy   = fin && !bad && !rdy;
        set_perr  = fin && bad;
        set_ovr   = fin && rdy;
    end

    // Capture the byte unless an unread byte is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_data <= '0;
        else if (load_data) rd_data <= byte_in;
    end

    // Ready flag: set by a good character; cleared by software or a DMA acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rdy <= 1'b0;
        else if (set_rdy)            rdy <= 1'b1;
        else if (clr_rdy || dma_ack) rdy <= 1'b0;
    end

    // Parity-error flag: sticky until a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        perr <= 1'b0;
        else if (set_perr) perr <= 1'b1;
        else if (clr_perr) perr <= 1'b0;
    end

    // Overrun flag: sticky until a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr <= 1'b0;
        else if (set_ovr) ovr <= 1'b1;
        else if (clr_ovr) ovr <= 1'b0;
    end

    // Derive the requests from the flags.
    always_comb begin
        rxi     = rdy && irq_en;
        eri     = (perr || ovr) && irq_en;
        dma_req = rdy;
    end
endmodule

// File: rtl/sc_char_rx.sv
// Module: top of the smart card character receiver.
// Synchronizes the shared line, then connects the timer, the sequencer and
// the flag logic. Assumes etu_div >= 2 and that etu_div does not change
// while a frame is in progress.
module sc_char_rx #(
    parameter int DIV_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_irq_en,
    input  logic [DIV_W-1:0]  etu_div,
    input  logic              io_in,
    output logic              io_drive_low,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy_flag,
    output logic              perr_flag,
    output logic              ovr_flag,
    input  logic              clr_rdy,
    input  logic              clr_perr,
    input  logic              clr_ovr,
    output logic              dma_req,
    input  logic              dma_ack,
    output logic              rxi_irq,
    output logic              eri_irq
);
    logic [1:0]        sync_q;
    logic              line_s;
    logic              tmr_load, tmr_done;
    logic [DIV_W-1:0]  tmr_val;
    logic              fin_w, bad_w;
    logic [DATA_W-1:0] byte_w;

    // Two-flop synchronizer for the line; it idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], io_in};
    end
    always_comb line_s = sync_q[1];

    sc_etu_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sc_rx_seq #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .line_s    (line_s),
        .etu_div   (etu_div),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .fin       (fin_w),
        .bad       (bad_w),
        .byte_out  (byte_w),
        .drive_low (io_drive_low)
    );

    sc_rx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .fin      (fin_w),
        .bad      (bad_w),
        .byte_in  (byte_w),
        .irq_en   (rx_irq_en),
        .clr_rdy  (clr_rdy),
        .clr_perr (clr_perr),
        .clr_ovr  (clr_ovr),
        .dma_ack  (dma_ack),
        .rd_data  (rd_data),
        .rdy      (rdy_flag),
        .perr     (perr_flag),
        .ovr      (ovr_flag),
        .rxi      (rxi_irq),
        .eri      (eri_irq),
        .dma_req  (dma_req)
    );
endmodule

// File: rtl/sc_char_rx_chk.sv
// Checker: temporal properties of sc_char_rx, attached with bind.
// The completion pulse and its parity verdict are taken from inside the top.
module sc_char_rx_chk #(
    parameter int DIV_W  = 12,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              rx_irq_en,
    input logic [DIV_W-1:0]  etu_div,
    input logic              io_drive_low,
    input logic [DATA_W-1:0] rd_data,
    input logic              rdy_flag,
    input logic              perr_flag,
    input logic              ovr_flag,
    input logic              dma_ack,
    input logic              rxi_irq,
    input logic              fin_w,
    input logic              bad_w
);
    logic [DIV_W:0] drv_cnt;
    logic           drv_prev, bad_seen;

    // Count consecutive cycles of error drive and remember a pending bad character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_cnt  <= '0;
            drv_prev <= 1'b0;
            bad_seen <= 1'b0;
        end else begin
            drv_cnt  <= io_drive_low ? drv_cnt + 1'b1 : '0;
            drv_prev <= io_drive_low;
            if (fin_w && bad_w)              bad_seen <= 1'b1;
            else if (drv_prev && !io_drive_low) bad_seen <= 1'b0;
        end
    end

    p_good_sets_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_w && !bad_w && !rdy_flag) |=> (rdy_flag && !perr_flag));
    p_bad_sets_perr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_w && bad_w) |=> perr_flag);
    p_bad_no_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_w && bad_w && !rdy_flag) |=> !rdy_flag);
    p_drive_after_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_drive_low) |-> bad_seen);
    p_drive_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(io_drive_low) && rx_en) |-> (drv_cnt == {1'b0, etu_div}));
    p_rxi_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rxi_irq |-> (rdy_flag && rx_irq_en));
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && rdy_flag && !fin_w) |=> !rdy_flag);
    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_w && rdy_flag) |=> (ovr_flag && $stable(rd_data)));
    p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !io_drive_low);
endmodule

bind sc_char_rx sc_char_rx_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_en        (rx_en),
    .rx_irq_en    (rx_irq_en),
    .etu_div      (etu_div),
    .io_drive_low (io_drive_low),
    .rd_data      (rd_data),
    .rdy_flag     (rdy_flag),
    .perr_flag    (perr_flag),
    .ovr_flag     (ovr_flag),
    .dma_ack      (dma_ack),
    .rxi_irq      (rxi_irq),
    .fin_w        (fin_w),
    .bad_w        (bad_w)
);

// File: tb/sc_char_rx_tb.sv
`timescale 1ns/1ps
module sc_char_rx_tb;
    localparam int DIV_W = 12;
    localparam int ETU   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, rx_irq_en = 1'b0;
    logic card_lvl = 1'b1;
    logic clr_rdy = 1'b0, clr_perr = 1'b0, clr_ovr = 1'b0, dma_ack = 1'b0;
    logic io_in, io_drive_low, rdy_flag, perr_flag, ovr_flag, dma_req, rxi_irq, eri_irq;
    logic [7:0] rd_data;

    int n_chk = 0, n_fail = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    typedef struct packed { logic [7:0] b; logic bad; } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;
    // Open-drain line: the card and the receiver can each pull it low.
    assign io_in = card_lvl & ~io_drive_low;

    sc_char_rx #(.DIV_W(DIV_W), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_irq_en(rx_irq_en),
        .etu_div(DIV_W'(ETU)), .io_in(io_in), .io_drive_low(io_drive_low),
        .rd_data(rd_data), .rdy_flag(rdy_flag), .perr_flag(perr_flag),
        .ovr_flag(ovr_flag), .clr_rdy(clr_rdy), .clr_perr(clr_perr),
        .clr_ovr(clr_ovr), .dma_req(dma_req), .dma_ack(dma_ack),
        .rxi_irq(rxi_irq), .eri_irq(eri_irq)
    );

    task automatic chk(input bit ok, input string tag, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // Driver: send one frame as the card; return the cycles of error drive seen.
    task automatic send_char(input logic [7:0] b, input bit bad_par,
                             input bit expect_rx, output int drv_cycles);
        logic [9:0] bits;
        bits = {(^b) ^ bad_par, b};
        if (expect_rx) exp_q.push_back({b, bad_par});
        @(negedge clk);
        card_lvl = 1'b0;
        repeat (ETU) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            card_lvl = bits[i];
            repeat (ETU) @(negedge clk);
        end
        card_lvl = 1'b1;
        drv_cycles = 0;
        for (int i = 0; i < 3 * ETU; i++) begin
            @(negedge clk);
            if (io_drive_low) drv_cycles++;
        end
        repeat (ETU) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pop the expected character when a result flag rises.
    logic prev_rdy = 1'b0, prev_perr = 1'b0;
    always @(negedge clk) begin
        if (mon_on && rst_n && ((rdy_flag && !prev_rdy) || (perr_flag && !prev_perr))) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R3", $sformatf("unexpected result data=%h rdy=%b perr=%b exp none",
                                           rd_data, rdy_flag, perr_flag));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rd_data == e.b, e.bad ? "R3" : "R2",
                    $sformatf("rd_data act=%h exp=%h", rd_data, e.b));
                chk(rdy_flag == !e.bad, e.bad ? "R3" : "R2",
                    $sformatf("rdy_flag act=%b exp=%b", rdy_flag, !e.bad));
                chk(perr_flag == e.bad, e.bad ? "R3" : "R2",
                    $sformatf("perr_flag act=%b exp=%b", perr_flag, e.bad));
            end
        end
        prev_rdy  <= rdy_flag;
        prev_perr <= perr_flag;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs after reset
        chk({rdy_flag, perr_flag, ovr_flag, rxi_irq, eri_irq, dma_req, io_drive_low} == 7'b0,
            "R1", $sformatf("flags act=%b exp=0",
            {rdy_flag, perr_flag, ovr_flag, rxi_irq, eri_irq, dma_req, io_drive_low}));
        chk(rd_data == 8'h00, "R1", $sformatf("rd_data act=%h exp=00", rd_data));

        rx_en = 1'b1; rx_irq_en = 1'b1; mon_on = 1'b1;
        repeat (ETU) @(negedge clk);

        // R2 good char, R4 no drive, R5/R6 requests
        send_char(8'hA5, 1'b0, 1'b1, d);
        chk(d == 0, "R4", $sformatf("drive cycles act=%0d exp=0", d));
        chk(rxi_irq == 1'b1, "R5", $sformatf("rxi_irq act=%b exp=1", rxi_irq));
        chk(dma_req == 1'b1, "R6", $sformatf("dma_req act=%b exp=1", dma_req));
        pulse(dma_ack);
        chk(rdy_flag == 1'b0 && dma_req == 1'b0, "R6",
            $sformatf("after ack rdy=%b dma_req=%b exp=0/0", rdy_flag, dma_req));

        // R3 bad char, R4 error drive length, R5 error irq, R8 clear
        send_char(8'h3C, 1'b1, 1'b1, d);
        chk(d == ETU, "R4", $sformatf("drive cycles act=%0d exp=%0d", d, ETU));
        chk(eri_irq == 1'b1, "R5", $sformatf("eri_irq act=%b exp=1", eri_irq));
        chk(dma_req == 1'b0, "R3", $sformatf("dma_req act=%b exp=0", dma_req));
        pulse(clr_perr);
        chk(perr_flag == 1'b0 && eri_irq == 1'b0, "R8",
            $sformatf("after clr perr=%b eri=%b exp=0/0", perr_flag, eri_irq));
        send_char(8'h3C, 1'b0, 1'b1, d);   // retransmission, good this time
        pulse(clr_rdy);
        chk(rdy_flag == 1'b0, "R8", $sformatf("after clr rdy act=%b exp=0", rdy_flag));

        // R7 overrun
        send_char(8'h01, 1'b0, 1'b1, d);
        send_char(8'h80, 1'b0, 1'b0, d);
        chk(ovr_flag == 1'b1, "R7", $sformatf("ovr_flag act=%b exp=1", ovr_flag));
        chk(rd_data == 8'h01, "R7", $sformatf("rd_data act=%h exp=01", rd_data));
        chk(eri_irq == 1'b1, "R5", $sformatf("eri on overrun act=%b exp=1", eri_irq));
        pulse(clr_ovr);
        chk(ovr_flag == 1'b0, "R8", $sformatf("after clr ovr act=%b exp=0", ovr_flag));
        pulse(clr_rdy);

        // R8 set wins over a clear held high through the frame
        clr_rdy = 1'b1;
        send_char(8'h5A, 1'b0, 1'b1, d);
        chk(rdy_flag == 1'b0, "R8", $sformatf("rdy after held clr act=%b exp=0", rdy_flag));
        clr_rdy = 1'b0;
        clr_perr = 1'b1;
        send_char(8'h77, 1'b1, 1'b1, d);
        clr_perr = 1'b0;
        chk(d == ETU, "R4", $sformatf("drive cycles act=%0d exp=%0d", d, ETU));

        // R5 irq gating
        rx_irq_en = 1'b0;
        send_char(8'h0F, 1'b0, 1'b1, d);
        chk(rxi_irq == 1'b0 && rdy_flag == 1'b1, "R5",
            $sformatf("gated rxi=%b rdy=%b exp=0/1", rxi_irq, rdy_flag));
        pulse(clr_rdy);
        rx_irq_en = 1'b1;

        // R9 false start
        @(negedge clk); card_lvl = 1'b0;
        repeat (4) @(negedge clk);
        card_lvl = 1'b1;
        d = 0;
        for (int i = 0; i < 12 * ETU; i++) begin
            @(negedge clk);
            if (io_drive_low) d++;
        end
        chk(!rdy_flag && !perr_flag && !ovr_flag && d == 0, "R9",
            $sformatf("rdy=%b perr=%b ovr=%b drv=%0d exp=0", rdy_flag, perr_flag, ovr_flag, d));

        // R10 disabled receiver
        rx_en = 1'b0;
        send_char(8'hC3, 1'b1, 1'b0, d);
        chk(d == 0 && !perr_flag && !rdy_flag, "R10",
            $sformatf("drv=%0d perr=%b rdy=%b exp=0", d, perr_flag, rdy_flag));
        rx_en = 1'b1;
        repeat (ETU) @(negedge clk);

        // R2 more patterns
        send_char(8'h00, 1'b0, 1'b1, d);
        pulse(clr_rdy);
        send_char(8'hFF, 1'b0, 1'b1, d);
        pulse(clr_rdy);
        send_char(8'h96, 1'b1, 1'b1, d);
        chk(d == ETU, "R4", $sformatf("drive cycles act=%0d exp=%0d", d, ETU));

        chk(exp_q.size() == 0, "R2", $sformatf("pending results act=%0d exp=0", exp_q.size()));
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule